// File: doc/BRIEF.md
# Glitch-Free Clock Switch

This block picks one of several free-running clocks and passes it to a single clock output. The clocks may differ in both frequency and phase. The select input may change at any moment, with no timing relation to any of the clocks, and the output still shows no runt pulse. Each clock input feeds its own branch. A branch captures its request on the rising edge of its own clock, and it updates the gate enable on the falling edge. As a result, a branch can open or close its gate only while its clock is low.

The branches are interlocked. A branch may start its enable sequence only when every other branch is idle in all of its stages. During a switch, the old clock finishes its last complete high phase. The output then stays low for a few cycles, and the new clock appears from the start of one of its own high phases. The default configuration has two clocks and a one-bit select.

Top module: `clk_switch_gf`

## Requirements
- R1: With select = 0 the output follows input clock 0, and with select = 1 it follows input clock 1, once the switch has settled. The output is high only while exactly one branch enable is high.
- R2: After a select change, the old clock stops within 1.5 of its own periods. The new clock then reaches the output within 2 of its own periods. A branch that is idle needs at least one full cycle of its clock before its enable can rise.
- R3: No two branches are ever active at once, counting every synchronizer stage. This holds even when the select pulses for less time than a switch takes.
- R4: Every high phase and every low phase of the output lasts at least the shorter input half-period. An enable changes only while its own clock is low.
- R5: An active-low reset clears every enable stage at once, without waiting for a clock. The output stays low, and does not rise, while reset is held.
- R6: After reset is released with both clocks running, the first rising edge of the output comes between 1 and 2 periods of the selected clock.
- R7: If the selected clock is stopped, the output stays low. A later selection of a running clock brings that clock to the output.
- R8: The select input may change at any phase relative to both clocks. R1 and R2 hold for every relative phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | NUM_CLK | Free-running input clocks, one per branch |
| rst_n | input | 1 | Asynchronous active-low reset for all enable stages |
| sel | input | SEL_W | Binary index of the wanted clock, may be asynchronous |
| clk_out | output | 1 | Selected clock, free of glitches |

## Verification
Each result has a known arrival time:
- After reset release, the first output rise is due 1 to 2 periods of the selected clock later.
- After a select change, the output follows the new clock within 1.5 periods of the old clock plus 2 periods of the new one.

The bench therefore waits a fixed window of three periods of each clock before comparing the output with the chosen input. It also measures the rise after reset against the 1-to-2-period bound. All clock edges fall on even time units, while every stimulus and every sample falls on an odd one. No comparison therefore lands on an edge.

Select changes are swept across every relative phase of the two clocks. Shorter select pulses exercise aborted switches. Throughout the run, a monitor measures the width of every output phase.

// File: rtl/cmx_pkg.sv
// Shared helpers for the glitch-free clock switch.
// Assumes: the clock count is at least 2.
package cmx_pkg;

    // Width of a binary index that can address n clocks.
    function automatic int unsigned sel_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/cmx_req_decode.sv
// Request decoder: turns the binary select into one request per branch.
// A branch is asked to start only when every other branch is idle in all
// of its stages.
// Assumes: the busy flags come from the branches and sel may be asynchronous
// (its value is only captured inside each branch's first stage).
module cmx_req_decode #(
    parameter int unsigned NUM_CLK = 2,
    parameter int unsigned SEL_W   = 1
) (
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [NUM_CLK-1:0] busy_i,
    output logic [NUM_CLK-1:0] req_o
);

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_req
        logic [NUM_CLK-1:0] peers;

        // Busy flags of every branch except this one.
        assign peers = busy_i & ~(NUM_CLK'(1) << i);

        // Request: selected and no other branch active in any stage.
        assign req_o[i] = (sel_i == SEL_W'(i)) && (peers == '0);
    end

endmodule

// File: rtl/cmx_branch.sv
// One clock branch: rising-edge capture chain, falling-edge enable stage,
// and the AND gate on its own clock.
// Assumes: clk_i is free-running or parked low, and rst_n is asynchronous
// and active-low. The enable changes only while clk_i is low, so the gated
// clock is never cut or started during a high phase.
module cmx_branch #(
    parameter int unsigned RISE_STAGES = 1
) (
    input  logic clk_i,
    input  logic rst_n,
    input  logic req_i,
    output logic busy_o,
    output logic en_o,
    output logic gclk_o
);

    logic [RISE_STAGES-1:0] rise_q;
    logic                   en_q;

    if (RISE_STAGES == 1) begin : g_one
        // Capture the request on the rising edge.
        always_ff @(posedge clk_i or negedge rst_n) begin
            if (!rst_n) rise_q <= '0;
            else        rise_q <= req_i;
        end
    end else begin : g_chain
        // Shift the request through the rising-edge synchronizer.
        always_ff @(posedge clk_i or negedge rst_n) begin
            if (!rst_n) rise_q <= '0;
            else        rise_q <= {rise_q[RISE_STAGES-2:0], req_i};
        end
    end

    // Move the enable on the falling edge, half a cycle after capture.
    always_ff @(negedge clk_i or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= rise_q[RISE_STAGES-1];
    end

    assign en_o   = en_q;
    assign busy_o = (|rise_q) | en_q;
    assign gclk_o = clk_i & en_q;

    // R4: the enable moves only while this branch's clock is low.
    always @(en_q) begin
        if (rst_n) begin
            assert_en_low_phase_R4: assert (!clk_i)
                else $error("enable changed during high phase");
        end
    end

    // R2: an idle branch cannot show its enable by the next falling edge.
    assert_idle_gap_R2: assert property (@(negedge clk_i) disable iff (!rst_n)
        !busy_o |=> !en_q)
        else $error("enable rose without a full capture cycle");

endmodule

// File: rtl/clk_switch_gf.sv
// Glitch-free clock switch: NUM_CLK branches, interlocked so that at most
// one branch is active in any stage. The output is the OR of the gated
// clocks.
// Assumes: sel is a binary index that may change at any time. A stopped
// clock must be parked low, and its branch must be idle or held in reset.
module clk_switch_gf
    import cmx_pkg::*;
#(
    parameter  int unsigned NUM_CLK     = 2,
    parameter  int unsigned RISE_STAGES = 1,
    localparam int unsigned SEL_W       = sel_width(NUM_CLK)
) (
    input  logic [NUM_CLK-1:0] clk_in,
    input  logic               rst_n,
    input  logic [SEL_W-1:0]   sel,
    output logic               clk_out
);

    logic [NUM_CLK-1:0] busy;
    logic [NUM_CLK-1:0] req;
    logic [NUM_CLK-1:0] en;
    logic [NUM_CLK-1:0] gclk;

    // Interlocked request generation.
    cmx_req_decode #(
        .NUM_CLK (NUM_CLK),
        .SEL_W   (SEL_W)
    ) u_dec (
        .sel_i  (sel),
        .busy_i (busy),
        .req_o  (req)
    );

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_br
        // Per-clock synchronizer and gate.
        cmx_branch #(
            .RISE_STAGES (RISE_STAGES)
        ) u_br (
            .clk_i  (clk_in[i]),
            .rst_n  (rst_n),
            .req_i  (req[i]),
            .busy_o (busy[i]),
            .en_o   (en[i]),
            .gclk_o (gclk[i])
        );

        // R3: seen from every clock, at most one branch is active.
        assert_busy_excl_R3: assert property (@(posedge clk_in[i])
            disable iff (!rst_n) $onehot0(busy))
            else $error("two branches active");
    end

    // Merge the gated clocks.
    assign clk_out = |gclk;

    // R1: an output rise comes from exactly one open gate.
    always @(posedge clk_out) begin
        if (rst_n) begin
            assert_out_src_R1: assert ($onehot(en))
                else $error("output rose without a single enable");
        end
    end

    // R5: the output never rises while reset is held.
    always @(posedge clk_out) begin
        assert_no_rise_in_reset_R5: assert (rst_n)
            else $error("output rose during reset");
    end

endmodule

// File: tb/sim_clk_switch_gf.sv
// Bench for clk_switch_gf with two unrelated clocks. Clock edges sit on
// even time units, and stimulus and samples on odd ones.
module sim_clk_switch_gf;

    localparam int CLK_PERIOD  = 12;
    localparam int CLK1_PERIOD = 28;
    localparam int H0          = CLK_PERIOD / 2;
    localparam int H1          = CLK1_PERIOD / 2;
    localparam int MIN_HALF    = (H0 < H1) ? H0 : H1;
    localparam int PHASE_SPAN  = CLK_PERIOD * CLK1_PERIOD / 4; // common period (gcd 4)
    localparam int SETTLE      = 3 * CLK_PERIOD + 3 * CLK1_PERIOD;
    localparam int TRACK       = 2 * CLK1_PERIOD;
    localparam int WATCHDOG_T  = 200000;

    logic clk0 = 1'b0;
    logic clk1 = 1'b0;
    logic run1 = 1'b1;
    logic rst_n;
    logic sel;
    logic clk_out;

    int n_chk = 0;
    int n_err = 0;
    int mon_chk = 0;
    int mon_err = 0;
    bit mon_on = 1'b0;
    bit have_last = 1'b0;
    longint last_edge = 0;

    clk_switch_gf u0 (
        .clk_in  ({clk1, clk0}),
        .rst_n   (rst_n),
        .sel     (sel),
        .clk_out (clk_out)
    );

    initial forever #H0 clk0 = ~clk0;

    initial begin
        #2;
        forever begin
            #H1;
            clk1 = run1 ? ~clk1 : 1'b0;
        end
    end

    // R4: every output phase is at least the shorter input half-period.
    always @(clk_out) begin
        if (mon_on && have_last) begin
            mon_chk++;
            if ($time - last_edge < MIN_HALF) begin
                mon_err++;
                $display("FAIL R4 phase width actual=%0d expected>=%0d", $time - last_edge, MIN_HALF);
            end
        end
        last_edge = $time;
        have_last = 1'b1;
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_track(input bit which, input string tag);
        int bad = 0;
        for (int t = 0; t < TRACK; t += 2) begin
            if (clk_out !== (which ? clk1 : clk0)) bad++;
            #2;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic expect_low(input int span, input string tag);
        int bad = 0;
        for (int t = 0; t < span; t += 2) begin
            if (clk_out !== 1'b0) bad++;
            #2;
        end
        check(bad == 0, tag, bad, 0);
    endtask

    task automatic measure_rise(input int period, input string tag);
        int dt = -1;
        for (int k = 0; k < 3 * period; k += 2) begin
            if (clk_out === 1'b1 && dt < 0) dt = k;
            #2;
        end
        check(dt >= period && dt <= 2 * period, tag, dt, period);
    endtask

    task automatic go_phase(input int ph);
        int cur;
        cur = int'($time % PHASE_SPAN);
        #((ph - cur + PHASE_SPAN) % PHASE_SPAN);
    endtask

    initial begin
        rst_n = 1'b0;
        sel   = 1'b0;
        #1;
        // R5: output low while held in reset.
        expect_low(5 * CLK_PERIOD, "R5 low in reset");

        // R6: bring-up of clock 0 after release.
        rst_n = 1'b1;
        have_last = 1'b0;
        mon_on = 1'b1;
        measure_rise(CLK_PERIOD, "R6 start clk0");
        #SETTLE;
        expect_track(1'b0, "R1 follow clk0");

        // R2/R8: switch both ways at every relative phase.
        for (int k = 0; k < PHASE_SPAN / 2; k++) begin
            go_phase(1 + 2 * k);
            sel = 1'b1;
            #SETTLE;
            expect_track(1'b1, "R2 R8 switch to clk1");
            sel = 1'b0;
            #SETTLE;
            expect_track(1'b0, "R2 R8 switch to clk0");
        end

        // R3: select pulses shorter than a switch.
        for (int w = 2; w <= 40; w += 2) begin
            sel = 1'b1;
            #w;
            sel = 1'b0;
            #w;
            sel = 1'b1;
            #SETTLE;
            expect_track(1'b1, "R3 aborted switch to clk1");
            sel = 1'b0;
            #w;
            sel = 1'b1;
            #w;
            sel = 1'b0;
            #SETTLE;
            expect_track(1'b0, "R3 aborted switch to clk0");
        end

        // R5/R6: reset in mid-run with clock 1 selected.
        sel = 1'b1;
        #SETTLE;
        mon_on = 1'b0;
        rst_n = 1'b0;
        expect_low(4 * CLK1_PERIOD, "R5 async clear mid-run");
        rst_n = 1'b1;
        have_last = 1'b0;
        mon_on = 1'b1;
        measure_rise(CLK1_PERIOD, "R6 start clk1");
        #SETTLE;
        expect_track(1'b1, "R1 follow clk1");

        // R7: stopped selected clock.
        mon_on = 1'b0;
        rst_n = 1'b0;
        run1 = 1'b0;
        #(2 * CLK1_PERIOD);
        rst_n = 1'b1;
        have_last = 1'b0;
        mon_on = 1'b1;
        expect_low(10 * CLK1_PERIOD, "R7 stopped clk1 gives low");
        sel = 1'b0;
        #SETTLE;
        expect_track(1'b0, "R7 recover to clk0");
        run1 = 1'b1;
        #(2 * CLK1_PERIOD);
        sel = 1'b1;
        #SETTLE;
        expect_track(1'b1, "R7 restarted clk1");

        mon_on = 1'b0;
        #2;
        $display("Result: errors=%0d of %0d checks", n_err + mon_err, n_chk + mon_chk);
        $finish;
    end

    initial begin
        #WATCHDOG_T;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_err + mon_err + 1, n_chk + mon_chk + 1);
        $finish;
    end

endmodule